// File: doc/BRIEF.md
# Sector Erase Suspend/Resume Controller

This block sequences one sector erase of a flash-style memory model at the command level. Decoded host commands arrive one per cycle with an address. An erase latches its target sector from the top address bits and runs for a fixed number of clock cycles. A suspend command can pause the erase. After a fixed suspend latency the block parks the erase. The host may then read the other sectors, program one word outside the erasing sector, or enter the device identification mode.

Two polling bits report progress. A done bit is low while the block is busy. A toggle bit flips on every status read taken while the block is busy. A resume command restarts the erase only if it names the suspended sector, and the remaining time carries over from where it stopped. After each resume the block drops any suspend for a configurable hold-off window, so suspend and resume can alternate without limit.

Top module: `flash_esr_ctl`

## Requirements
- R1: After reset, erase_active_o, suspended_o, prog_busy_o and id_mode_o are 0, poll_done_o is 1 and rd_kind_o is 0.
- R2: An erase command (op 1) accepted while idle or done sets erase_active_o and poll_done_o=0 in the next cycle and sets erase_sector_o to the top SECT_W address bits. With no suspend, erase_active_o stays high for exactly ERASE_CYCLES cycles, and poll_done_o then returns to 1.
- R3: A suspend (op 2) accepted while erasing makes suspended_o rise exactly SUSP_LAT cycles after the accepting edge. A suspend given while no erase is active is ignored.
- R4: The remaining erase time is frozen while suspended. Across any number of suspends, the total number of cycles with erase_active_o high equals ERASE_CYCLES.
- R5: A resume (op 3) restarts the erase only when its top SECT_W address bits equal the suspended sector. A resume naming any other sector leaves the block suspended.
- R6: A resume given while the erase is running is ignored, and the completion time does not change.
- R7: For GAP_CYCLES cycles after the edge that accepts a resume, suspend commands are dropped. A suspend at the next edge is accepted, and suspend/resume may repeat.
- R8: A read (op 5) sets rd_kind_o for one cycle on the next cycle. Code 1 means array data, 2 means status and 3 means identification data. Reads give 2 while erasing, suspending or programming. While suspended, reads give 2 for the erasing sector and 1 for other sectors. Reads give 1 when idle or done.
- R9: While suspended, a program (op 4) outside the erasing sector raises prog_busy_o for PROG_CYCLES cycles and then returns to suspended. A program aimed at the erasing sector, or given in identification mode, is ignored.
- R10: While suspended, op 6 sets id_mode_o and op 7 clears it. While id_mode_o is set, reads give code 3. A resume also clears id_mode_o.
- R11: poll_done_o is 0 while erasing, suspending or programming. poll_toggle_o flips on each read taken in those states and holds on reads while parked in suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | Opcode: 0 none, 1 erase, 2 suspend, 3 resume, 4 program, 5 read, 6 id enter, 7 id exit |
| cmd_addr_i | input | ADDR_W | Command address; top SECT_W bits select the sector |
| erase_active_o | output | 1 | Erase running |
| suspended_o | output | 1 | Erase parked, host access allowed |
| prog_busy_o | output | 1 | Program in progress during suspend |
| erase_sector_o | output | SECT_W | Sector latched by the last erase |
| poll_done_o | output | 1 | Low while busy |
| poll_toggle_o | output | 1 | Flips on each status read while busy |
| rd_kind_o | output | 2 | Read result class, valid one cycle |
| id_mode_o | output | 1 | Identification mode active |

## Verification
The bench builds the block with ADDR_W=8, SECT_W=2, ERASE_CYCLES=40, SUSP_LAT=3, GAP_CYCLES=4 and PROG_CYCLES=5. With a 40-cycle erase, several suspend/resume rounds fit inside one erase, including a suspend issued on every edge of the hold-off window and on the first edge after it. The short suspend and program latencies let the bench count exact cycle edges. With four sectors the bench can aim commands at the erasing sector and at other sectors.

// File: rtl/flash_esr_pkg.sv
package flash_esr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_SUSPING,
    ST_SUSP,
    ST_PROG,
    ST_DONE
  } fes_state_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ERASE   = 3'd1,
    OP_SUSPEND = 3'd2,
    OP_RESUME  = 3'd3,
    OP_PROG    = 3'd4,
    OP_READ    = 3'd5,
    OP_ID_ON   = 3'd6,
    OP_ID_OFF  = 3'd7
  } fes_op_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ARRAY  = 2'd1,
    RD_STATUS = 2'd2,
    RD_IDENT  = 2'd3
  } fes_rd_e;

endpackage

// File: rtl/flash_dcount.sv
module flash_dcount #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/flash_sect_match.sv
module flash_sect_match #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [SECT_W-1:0] sect_o,
  output logic              hit_o
);

  logic unused_addr_lo;

  assign sect_o         = addr_i[ADDR_W-1 -: SECT_W];
  assign hit_o          = (sect_o == sect_i);
  assign unused_addr_lo = ^addr_i[ADDR_W-SECT_W-1:0];

endmodule

// File: rtl/flash_esr_ctl.sv
module flash_esr_ctl
  import flash_esr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECT_W       = 4,
  parameter int ERASE_CYCLES = 5000,
  parameter int SUSP_LAT     = 4,
  parameter int GAP_CYCLES   = 6,
  parameter int PROG_CYCLES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              erase_active_o,
  output logic              suspended_o,
  output logic              prog_busy_o,
  output logic [SECT_W-1:0] erase_sector_o,
  output logic              poll_done_o,
  output logic              poll_toggle_o,
  output logic [1:0]        rd_kind_o,
  output logic              id_mode_o
);

  localparam int EW      = $clog2(ERASE_CYCLES + 1);
  localparam int AUX_MAX = (SUSP_LAT > PROG_CYCLES) ? SUSP_LAT : PROG_CYCLES;
  localparam int AW      = $clog2(AUX_MAX + 1);
  localparam int GW      = $clog2(GAP_CYCLES + 1);

  fes_state_e        state_q, state_d;
  logic [SECT_W-1:0] sect_q;
  logic [SECT_W-1:0] cmd_sect;
  logic              sect_hit;
  logic              id_q;
  logic              toggle_q;
  fes_rd_e           rd_q, rd_d;

  logic [EW-1:0] rem_cnt;
  logic [AW-1:0] aux_cnt, aux_val;
  logic [GW-1:0] guard_cnt;

  logic erase_go, susp_go, resume_go, prog_go;
  logic busy, is_rd;

  function automatic logic op_is(input fes_op_e op);
    return cmd_valid_i && (cmd_op_i == op);
  endfunction

  flash_sect_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_match (
    .addr_i (cmd_addr_i),
    .sect_i (sect_q),
    .sect_o (cmd_sect),
    .hit_o  (sect_hit)
  );

  // remaining erase time, only moves while erasing
  flash_dcount #(.W(EW)) u_rem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (erase_go),
    .load_val_i (EW'(ERASE_CYCLES)),
    .dec_i      (state_q == ST_ERASE),
    .count_o    (rem_cnt)
  );

  // suspend latency and in-suspend program share one timer
  assign aux_val = susp_go ? AW'(SUSP_LAT) : AW'(PROG_CYCLES);

  flash_dcount #(.W(AW)) u_aux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (susp_go || prog_go),
    .load_val_i (aux_val),
    .dec_i      (state_q == ST_SUSPING || state_q == ST_PROG),
    .count_o    (aux_cnt)
  );

  // resume-to-suspend hold-off
  flash_dcount #(.W(GW)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (resume_go),
    .load_val_i (GW'(GAP_CYCLES)),
    .dec_i      (1'b1),
    .count_o    (guard_cnt)
  );

  always_comb begin
    state_d   = state_q;
    erase_go  = 1'b0;
    susp_go   = 1'b0;
    resume_go = 1'b0;
    prog_go   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (op_is(OP_ERASE)) begin
          state_d  = ST_ERASE;
          erase_go = 1'b1;
        end
      end
      ST_ERASE: begin
        // completion wins over a same-cycle suspend
        if (rem_cnt == EW'(1)) begin
          state_d = ST_DONE;
        end else if (op_is(OP_SUSPEND) && guard_cnt == '0) begin
          state_d = ST_SUSPING;
          susp_go = 1'b1;
        end
      end
      ST_SUSPING: begin
        if (aux_cnt == AW'(1)) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (op_is(OP_RESUME) && sect_hit) begin
          state_d   = ST_ERASE;
          resume_go = 1'b1;
        end else if (op_is(OP_PROG) && !sect_hit && !id_q) begin
          state_d = ST_PROG;
          prog_go = 1'b1;
        end
      end
      ST_PROG: begin
        if (aux_cnt == AW'(1)) state_d = ST_SUSP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy  = (state_q == ST_ERASE) || (state_q == ST_SUSPING) || (state_q == ST_PROG);
  assign is_rd = op_is(OP_READ);

  always_comb begin
    rd_d = RD_NONE;
    if (is_rd) begin
      if (id_q)                    rd_d = RD_IDENT;
      else if (busy)               rd_d = RD_STATUS;
      else if (state_q == ST_SUSP) rd_d = sect_hit ? RD_STATUS : RD_ARRAY;
      else                         rd_d = RD_ARRAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sect_q   <= '0;
      id_q     <= 1'b0;
      toggle_q <= 1'b0;
      rd_q     <= RD_NONE;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      if (erase_go) sect_q <= cmd_sect;
      if (resume_go || (state_q == ST_SUSP && op_is(OP_ID_OFF)))
        id_q <= 1'b0;
      else if (state_q == ST_SUSP && op_is(OP_ID_ON))
        id_q <= 1'b1;
      if (is_rd && busy) toggle_q <= ~toggle_q;
    end
  end

  assign erase_active_o = (state_q == ST_ERASE);
  assign suspended_o    = (state_q == ST_SUSP);
  assign prog_busy_o    = (state_q == ST_PROG);
  assign erase_sector_o = sect_q;
  assign poll_done_o    = ~busy;
  assign poll_toggle_o  = toggle_q;
  assign rd_kind_o      = rd_q;
  assign id_mode_o      = id_q;

endmodule

// File: rtl/flash_esr_chk.sv
module flash_esr_chk
  import flash_esr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SECT_W     = 4,
  parameter int GAP_CYCLES = 6,
  parameter int EW         = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input fes_state_e        state_q,
  input logic [SECT_W-1:0] sect_q,
  input logic [EW-1:0]     rem_cnt,
  input logic              erase_active_o,
  input logic              suspended_o,
  input logic              prog_busy_o,
  input logic              id_mode_o
);

  localparam int CW = $clog2(GAP_CYCLES + 2) + 1;

  logic [SECT_W-1:0] c_sect;
  logic              unused_lo;
  fes_state_e        prev_q;
  logic [CW-1:0]     gap_cnt;

  assign c_sect    = cmd_addr_i[ADDR_W-1 -: SECT_W];
  assign unused_lo = ^cmd_addr_i[ADDR_W-SECT_W-1:0];

  // cycles since the erase last restarted from suspend
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= ST_IDLE;
      gap_cnt <= CW'(GAP_CYCLES + 1);
    end else begin
      prev_q <= state_q;
      if (state_q == ST_ERASE && prev_q == ST_SUSP) gap_cnt <= CW'(1);
      else if (gap_cnt <= CW'(GAP_CYCLES))          gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_NO_SUSPEND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE || $past(state_q) == ST_DONE) |-> state_q != ST_SUSPING); // R3

  AST_REM_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_SUSPING || $past(state_q) == ST_SUSP || $past(state_q) == ST_PROG)
      |-> $stable(rem_cnt)); // R4

  AST_RESUME_SECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_active_o && $past(suspended_o))
      |-> ($past(cmd_valid_i) && $past(cmd_op_i) == OP_RESUME && $past(c_sect) == sect_q)); // R5

  AST_RESUME_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(erase_active_o) && $past(cmd_valid_i) && $past(cmd_op_i) == OP_RESUME
      && $past(rem_cnt) != EW'(1)) |-> erase_active_o); // R6

  AST_SUSP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSPING && $past(state_q) == ST_ERASE) |-> gap_cnt > CW'(GAP_CYCLES)); // R7

  AST_PROG_OTHER_SECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_busy_o && !$past(prog_busy_o)) |-> $past(c_sect) != sect_q); // R9

  AST_ID_IN_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_mode_o |-> suspended_o); // R10

endmodule

bind flash_esr_ctl flash_esr_chk #(
  .ADDR_W     (ADDR_W),
  .SECT_W     (SECT_W),
  .GAP_CYCLES (GAP_CYCLES),
  .EW         (EW)
) u_chk (.*);

// File: tb/flash_esr_ctl_tb.sv
module flash_esr_ctl_tb;

  localparam int ADDR_W = 8;
  localparam int SECT_W = 2;
  localparam int ERASE  = 40;
  localparam int SLAT   = 3;
  localparam int GAP    = 4;
  localparam int PROG   = 5;

  localparam logic [2:0] C_ERASE = 3'd1, C_SUSP = 3'd2, C_RES = 3'd3, C_PROG = 3'd4,
                         C_READ = 3'd5, C_IDON = 3'd6, C_IDOFF = 3'd7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              erase_active, suspended, prog_busy, poll_done, poll_toggle, id_mode;
  logic [SECT_W-1:0] erase_sector;
  logic [1:0]        rd_kind;

  int n_chk = 0;
  int n_fail = 0;
  int act_cnt = 0;

  always #4 clk = ~clk;

  flash_esr_ctl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .ERASE_CYCLES(ERASE),
    .SUSP_LAT(SLAT), .GAP_CYCLES(GAP), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .erase_active_o(erase_active), .suspended_o(suspended),
    .prog_busy_o(prog_busy), .erase_sector_o(erase_sector), .poll_done_o(poll_done),
    .poll_toggle_o(poll_toggle), .rd_kind_o(rd_kind), .id_mode_o(id_mode)
  );

  always @(negedge clk) if (erase_active) act_cnt++;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkv(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // caller sits at a negedge; command is seen by exactly one posedge
  task automatic cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!poll_done && k < 500) begin @(negedge clk); k++; end
    chk(poll_done, req, 0, 1);
  endtask

  task automatic wait_susp(input string req);
    int k = 0;
    while (!suspended && k < 50) begin @(negedge clk); k++; end
    chk(suspended, req, 0, 1);
  endtask

  task automatic t_reset;
    chkv("R1 erase_active", erase_active, 0);
    chkv("R1 suspended", suspended, 0);
    chkv("R1 prog_busy", prog_busy, 0);
    chkv("R1 id_mode", id_mode, 0);
    chkv("R1 poll_done", poll_done, 1);
    chkv("R1 rd_kind", rd_kind, 0);
  endtask

  task automatic t_plain_erase;
    act_cnt = 0;
    cmd(C_ERASE, 8'h80);
    chkv("R2 active", erase_active, 1);
    chkv("R2 sector", erase_sector, 2);
    chkv("R2 poll_done low", poll_done, 0);
    wait_done("R2 completes");
    chkv("R2 active cycles", act_cnt, ERASE);
    cmd(C_READ, 8'h81);
    chkv("R8 read when done", rd_kind, 1);
  endtask

  task automatic t_suspend_idle;
    cmd(C_SUSP, 8'h80);
    idle(SLAT + 1);
    chkv("R3 idle suspend ignored", suspended, 0);
    chkv("R3 idle suspend poll", poll_done, 1);
  endtask

  task automatic t_suspend_resume;
    logic tg;
    act_cnt = 0;
    cmd(C_ERASE, 8'h40);
    idle(10);
    cmd(C_SUSP, 8'h40);
    chkv("R4 frozen not active", erase_active, 0);
    tg = poll_toggle;
    cmd(C_READ, 8'hC0);
    chkv("R8 read while suspending", rd_kind, 2);
    chkv("R11 toggle flips suspending", poll_toggle, int'(!tg));
    idle(1);
    chkv("R3 latency not yet", suspended, 0);
    idle(1);
    chkv("R3 latency reached", suspended, 1);
    chkv("R11 done bit when parked", poll_done, 1);
    tg = poll_toggle;
    cmd(C_READ, 8'h45);
    chkv("R8 erasing sector status", rd_kind, 2);
    chkv("R11 toggle holds parked", poll_toggle, int'(tg));
    cmd(C_READ, 8'hC0);
    chkv("R8 other sector array", rd_kind, 1);
    cmd(C_RES, 8'h00);
    chkv("R5 wrong sector ignored", suspended, 1);
    cmd(C_RES, 8'h4F);
    chkv("R5 matching resume", erase_active, 1);
    cmd(C_RES, 8'h4F);
    chkv("R6 repeat resume ignored", erase_active, 1);
    tg = poll_toggle;
    cmd(C_READ, 8'hC0);
    chkv("R8 read while erasing", rd_kind, 2);
    chkv("R11 toggle flips erasing", poll_toggle, int'(!tg));
    wait_done("R4 completes");
    chkv("R4 total active cycles", act_cnt, ERASE);
  endtask

  task automatic t_gap;
    act_cnt = 0;
    cmd(C_ERASE, 8'hC0);
    idle(3);
    cmd(C_SUSP, 8'hC0);
    wait_susp("R7 first suspend");
    cmd(C_RES, 8'hC1);
    for (int i = 0; i < GAP; i++) begin
      cmd(C_SUSP, 8'hC0);
      chkv("R7 suspend in gap dropped", erase_active, 1);
    end
    cmd(C_SUSP, 8'hC0);
    chkv("R7 suspend after gap", erase_active, 0);
    wait_susp("R7 second suspend");
    cmd(C_RES, 8'hC2);
    idle(GAP);
    cmd(C_SUSP, 8'hC0);
    chkv("R7 third suspend", erase_active, 0);
    wait_susp("R7 third parked");
    cmd(C_RES, 8'hC3);
    wait_done("R7 completes");
    chkv("R4 active cycles with rounds", act_cnt, ERASE);
  endtask

  task automatic t_prog;
    logic tg;
    cmd(C_ERASE, 8'h10);
    cmd(C_SUSP, 8'h10);
    wait_susp("R9 parked");
    cmd(C_PROG, 8'h05);
    chkv("R9 same sector program ignored", prog_busy, 0);
    cmd(C_PROG, 8'h90);
    chkv("R9 program starts", prog_busy, 1);
    chkv("R11 busy during program", poll_done, 0);
    tg = poll_toggle;
    cmd(C_READ, 8'h90);
    chkv("R8 read during program", rd_kind, 2);
    chkv("R11 toggle flips program", poll_toggle, int'(!tg));
    cmd(C_READ, 8'h90);
    chkv("R11 toggle flips back", poll_toggle, int'(tg));
    idle(PROG - 3);
    chkv("R9 still programming", prog_busy, 1);
    idle(1);
    chkv("R9 program ends", prog_busy, 0);
    chkv("R9 back to suspended", suspended, 1);
    cmd(C_RES, 8'h00);
    wait_done("R9 erase completes");
  endtask

  task automatic t_ident;
    cmd(C_ERASE, 8'h50);
    cmd(C_IDON, 8'h00);
    chkv("R10 id ignored while erasing", id_mode, 0);
    cmd(C_SUSP, 8'h50);
    wait_susp("R10 parked");
    cmd(C_IDON, 8'h00);
    chkv("R10 id enter", id_mode, 1);
    cmd(C_READ, 8'hC0);
    chkv("R10 ident read", rd_kind, 3);
    cmd(C_PROG, 8'hC0);
    chkv("R9 program in id mode ignored", prog_busy, 0);
    cmd(C_IDOFF, 8'h00);
    chkv("R10 id exit", id_mode, 0);
    cmd(C_READ, 8'hC0);
    chkv("R10 array read after exit", rd_kind, 1);
    cmd(C_IDON, 8'h00);
    cmd(C_RES, 8'h50);
    chkv("R10 resume clears id", id_mode, 0);
    chkv("R10 resume restarts", erase_active, 1);
    wait_done("R10 completes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_plain_erase();
    t_suspend_idle();
    t_suspend_resume();
    t_gap();
    t_prog();
    t_ident();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule